// File: doc/BRIEF.md
# Grouped GPIO Bank Controller

This block controls 64 general-purpose lines arranged as eight groups of eight. Line `n` belongs to group `n/8` and sits at bit `n%8` of every per-group byte. Direction and function selection are reached through a byte-wide configuration port. Line data is reached through a separate byte-wide I/O port, where each group owns one data register at a fixed offset from a base address.

The configuration space has two kinds of register. Each group has an output-enable byte. The lower groups (five by default) also have a simple-I/O enable byte. When a line's simple-I/O enable is clear, the pad is handed to an alternate function: its drive value and drive enable come from the alternate-function inputs. Groups above the switched range have no such switch and always run as plain GPIO.

A data-register write loads the group's output latch. Software that wants to change a single line reads the byte, changes one bit and writes the whole byte back. A data-register read returns the latch bit for output lines and the synchronised pad level for input lines. Pad drive and pad enable leave the block through registers.

Top module: `gpio_bank`

## Requirements
- R1: While reset is held and on the first cycle after it, all output enables, simple-I/O enables and latches are zero, `pad_oe` and `pad_out` are all zero, and configuration and data reads return 0x00.
- R2: Line n maps to group n/8 and to bit n%8 of that group's output-enable, simple-I/O, latch and data bytes.
- R3: The output-enable byte of group g sits at configuration address 0xC8+g. A 1 bit makes the line an output and a 0 bit makes it an input. The byte reads back unchanged.
- R4: The simple-I/O enable byte of group g sits at configuration address 0xC0+g, for g below 5 only. Writes to 0xC5..0xC7 change no register and reads there return 0x00. Any other unmapped configuration address also reads 0x00.
- R5: A write to I/O address IO_BASE+g (g in 0..7) loads the whole latch byte of group g.
- R6: A data read returns, for each bit, the latch bit when the line is an output and the pin level when it is an input. The pin path runs through two synchronising flops, so a pin change made between two edges first shows on `io_rdata` after the third following edge.
- R7: In groups 0..4 with simple-I/O enable set, `pad_oe` equals the output enable and `pad_out` equals the latch bit.
- R8: In groups 0..4 with simple-I/O enable clear, `pad_oe` equals `alt_func_oe` and `pad_out` equals `alt_func_out` for that line, whatever the output enable and latch hold.
- R9: In groups 5..7, `pad_oe` equals the output enable and `pad_out` equals the latch bit.
- R10: `pad_oe` and `pad_out` are registered. They reflect a register write or an alternate-function input change one clock after the edge on which that change is taken in.
- R11: I/O writes outside IO_BASE..IO_BASE+7 change no latch, and I/O reads there return 0x00.
- R12: `cfg_rdata` and `io_rdata` present, one clock later, the register addressed on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rdata | output | 8 | Registered configuration read data |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Data register write value |
| io_we | input | 1 | Data register write strobe |
| io_rdata | output | 8 | Registered data register read value |
| pin_in | input | 64 | Asynchronous pad input levels |
| alt_func_out | input | 40 | Alternate-function drive values for groups 0..4 |
| alt_func_oe | input | 40 | Alternate-function drive enables for groups 0..4 |
| pad_out | output | 64 | Registered pad drive value |
| pad_oe | output | 64 | Registered pad drive enable |

## Verification
The hardest state to reach is a switched group where output enable, simple-I/O enable and alternate-function inputs all disagree bit by bit. Only then do the pad multiplexer and the readback multiplexer pick different sources for neighbouring lines. Random byte writes to both configuration windows, including the dead addresses 0xC5..0xC7, are interleaved with random alternate-function and pin patterns, so such mixed bytes occur often. Directed steps pin down the two-flop read latency and the one-cycle pad latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Offset of an address into a window, and whether it falls inside it.
  function automatic logic win_hit(input logic [15:0] addr, input logic [15:0] base,
                                   input int unsigned count);
    logic [15:0] off;
    off = addr - base;
    return (32'(off) < count);
  endfunction

endpackage

// File: rtl/gpio_bank_cfg.sv
module gpio_bank_cfg #(
  parameter int NUM_GROUPS = 8,
  parameter int GW         = 8,
  parameter int SIO_GROUPS = 5,
  parameter int AW         = 8,
  parameter logic [AW-1:0] OE_BASE  = 8'hC8,
  parameter logic [AW-1:0] SIO_BASE = 8'hC0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [AW-1:0]              cfg_addr,
  input  logic [GW-1:0]              cfg_wdata,
  input  logic                       cfg_we,
  output logic [GW-1:0]              cfg_rdata,
  output logic [NUM_GROUPS*GW-1:0]   oe_flat,
  output logic [SIO_GROUPS*GW-1:0]   sio_flat
);
  import gpio_bank_pkg::*;

  localparam int IW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic [GW-1:0] oe_q  [NUM_GROUPS];
  logic [GW-1:0] sio_q [SIO_GROUPS];
  logic [AW-1:0] oe_off, sio_off;
  logic          oe_hit, sio_hit;
  logic [IW-1:0] oe_idx, sio_idx;
  logic [GW-1:0] rd_next;

  assign oe_off  = cfg_addr - OE_BASE;
  assign sio_off = cfg_addr - SIO_BASE;
  assign oe_hit  = win_hit(16'(cfg_addr), 16'(OE_BASE), NUM_GROUPS);
  assign sio_hit = win_hit(16'(cfg_addr), 16'(SIO_BASE), SIO_GROUPS);
  assign oe_idx  = oe_off[IW-1:0];
  assign sio_idx = sio_off[IW-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_oe
    always_ff @(posedge clk) begin
      if (rst) oe_q[g] <= '0;
      else if (cfg_we && oe_hit && oe_idx == IW'(g)) oe_q[g] <= cfg_wdata;
    end
    assign oe_flat[g*GW +: GW] = oe_q[g];
  end

  for (genvar g = 0; g < SIO_GROUPS; g++) begin : g_sio
    always_ff @(posedge clk) begin
      if (rst) sio_q[g] <= '0;
      else if (cfg_we && sio_hit && sio_idx == IW'(g)) sio_q[g] <= cfg_wdata;
    end
    assign sio_flat[g*GW +: GW] = sio_q[g];
  end

  always_comb begin
    rd_next = '0;
    if (oe_hit)       rd_next = oe_q[oe_idx];
    else if (sio_hit) rd_next = sio_q[sio_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/gpio_bank_group.sv
module gpio_bank_group #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [GW-1:0] wdata,
  input  logic [GW-1:0] oe,
  input  logic [GW-1:0] sio,
  input  logic [GW-1:0] alt_out,
  input  logic [GW-1:0] alt_oe,
  input  logic [GW-1:0] pin_sync,
  output logic [GW-1:0] latch,
  output logic [GW-1:0] rd_byte,
  output logic [GW-1:0] pad_out,
  output logic [GW-1:0] pad_oe
);

  always_ff @(posedge clk) begin
    if (rst)        latch <= '0;
    else if (wr_en) latch <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= (sio & latch) | (~sio & alt_out);
      pad_oe  <= (sio & oe)    | (~sio & alt_oe);
    end
  end

  assign rd_byte = (oe & latch) | (~oe & pin_sync);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NUM_GROUPS = 8,
  parameter int GW         = 8,
  parameter int SIO_GROUPS = 5,
  parameter int CFG_AW     = 8,
  parameter int IO_AW      = 16,
  parameter logic [CFG_AW-1:0] OE_BASE  = 8'hC8,
  parameter logic [CFG_AW-1:0] SIO_BASE = 8'hC0,
  parameter logic [IO_AW-1:0]  IO_BASE  = 16'h0A00
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [GW-1:0]                cfg_wdata,
  input  logic                         cfg_we,
  output logic [GW-1:0]                cfg_rdata,
  input  logic [IO_AW-1:0]             io_addr,
  input  logic [GW-1:0]                io_wdata,
  input  logic                         io_we,
  output logic [GW-1:0]                io_rdata,
  input  logic [NUM_GROUPS*GW-1:0]     pin_in,
  input  logic [SIO_GROUPS*GW-1:0]     alt_func_out,
  input  logic [SIO_GROUPS*GW-1:0]     alt_func_oe,
  output logic [NUM_GROUPS*GW-1:0]     pad_out,
  output logic [NUM_GROUPS*GW-1:0]     pad_oe
);
  import gpio_bank_pkg::*;

  localparam int LINES = NUM_GROUPS * GW;
  localparam int IW    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic [LINES-1:0]         oe_flat;
  logic [SIO_GROUPS*GW-1:0] sio_flat;
  logic [LINES-1:0]         pin_sync;
  logic [LINES-1:0]         latch_flat;
  logic [GW-1:0]            rd_bytes [NUM_GROUPS];
  logic [IO_AW-1:0]         io_off;
  logic                     io_hit;
  logic [IW-1:0]            io_idx;

  gpio_bank_cfg #(
    .NUM_GROUPS(NUM_GROUPS), .GW(GW), .SIO_GROUPS(SIO_GROUPS), .AW(CFG_AW),
    .OE_BASE(OE_BASE), .SIO_BASE(SIO_BASE)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .oe_flat(oe_flat), .sio_flat(sio_flat)
  );

  gpio_bank_sync #(.W(LINES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  assign io_off = io_addr - IO_BASE;
  assign io_hit = win_hit(16'(io_addr), 16'(IO_BASE), NUM_GROUPS);
  assign io_idx = io_off[IW-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [GW-1:0] sio_b, alt_o, alt_e;
    if (g < SIO_GROUPS) begin : g_sw
      assign sio_b = sio_flat[g*GW +: GW];
      assign alt_o = alt_func_out[g*GW +: GW];
      assign alt_e = alt_func_oe[g*GW +: GW];
    end else begin : g_fixed
      assign sio_b = '1;
      assign alt_o = '0;
      assign alt_e = '0;
    end
    gpio_bank_group #(.GW(GW)) u_group (
      .clk(clk), .rst(rst),
      .wr_en(io_we && io_hit && io_idx == IW'(g)),
      .wdata(io_wdata),
      .oe(oe_flat[g*GW +: GW]),
      .sio(sio_b),
      .alt_out(alt_o),
      .alt_oe(alt_e),
      .pin_sync(pin_sync[g*GW +: GW]),
      .latch(latch_flat[g*GW +: GW]),
      .rd_byte(rd_bytes[g]),
      .pad_out(pad_out[g*GW +: GW]),
      .pad_oe(pad_oe[g*GW +: GW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         io_rdata <= '0;
    else if (io_hit) io_rdata <= rd_bytes[io_idx];
    else             io_rdata <= '0;
  end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_GROUPS = 8,
  parameter int GW         = 8,
  parameter int SIO_GROUPS = 5,
  parameter int CFG_AW     = 8,
  parameter int IO_AW      = 16,
  parameter logic [CFG_AW-1:0] OE_BASE  = 8'hC8,
  parameter logic [CFG_AW-1:0] SIO_BASE = 8'hC0,
  parameter logic [IO_AW-1:0]  IO_BASE  = 16'h0A00
) (
  input logic                         clk,
  input logic                         rst,
  input logic [CFG_AW-1:0]            cfg_addr,
  input logic                         cfg_we,
  input logic [IO_AW-1:0]             io_addr,
  input logic                         io_we,
  input logic [GW-1:0]                io_rdata,
  input logic [NUM_GROUPS*GW-1:0]     oe_flat,
  input logic [SIO_GROUPS*GW-1:0]     sio_flat,
  input logic [NUM_GROUPS*GW-1:0]     latch_flat,
  input logic [SIO_GROUPS*GW-1:0]     alt_func_out,
  input logic [SIO_GROUPS*GW-1:0]     alt_func_oe,
  input logic [NUM_GROUPS*GW-1:0]     pad_out,
  input logic [NUM_GROUPS*GW-1:0]     pad_oe
);
  localparam int LO = SIO_GROUPS * GW;
  localparam int TOT = NUM_GROUPS * GW;
  localparam logic [CFG_AW-1:0] GAP_LO = SIO_BASE + CFG_AW'(SIO_GROUPS);

  logic [IO_AW-1:0] io_off;
  assign io_off = io_addr - IO_BASE;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && io_rdata == '0 &&
             oe_flat == '0 && latch_flat == '0));

  assert_dead_cfg_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr >= GAP_LO && cfg_addr < OE_BASE)
      |=> ($stable(oe_flat) && $stable(sio_flat)));

  assert_io_outside_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (io_we && 32'(io_off) >= NUM_GROUPS) |=> $stable(latch_flat));

  assert_switched_pads_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      (pad_oe[LO-1:0] == $past((oe_flat[LO-1:0] & sio_flat) | (~sio_flat & alt_func_oe)) &&
       pad_out[LO-1:0] == $past((latch_flat[LO-1:0] & sio_flat) | (~sio_flat & alt_func_out))));

  assert_fixed_pads_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      (pad_oe[TOT-1:LO] == $past(oe_flat[TOT-1:LO]) &&
       pad_out[TOT-1:LO] == $past(latch_flat[TOT-1:LO])));

endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_GROUPS(NUM_GROUPS), .GW(GW), .SIO_GROUPS(SIO_GROUPS), .CFG_AW(CFG_AW),
  .IO_AW(IO_AW), .OE_BASE(OE_BASE), .SIO_BASE(SIO_BASE), .IO_BASE(IO_BASE)
) u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
  .io_addr(io_addr), .io_we(io_we), .io_rdata(io_rdata),
  .oe_flat(oe_flat), .sio_flat(sio_flat), .latch_flat(latch_flat),
  .alt_func_out(alt_func_out), .alt_func_oe(alt_func_oe),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam logic [15:0] IOB = 16'h0A00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic        cfg_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic        io_we = 1'b0;
  logic [63:0] pin_in = '0;
  logic [39:0] alt_func_out = '0, alt_func_oe = '0;
  logic [63:0] pad_out, pad_oe;

  logic [7:0] oe_m [8];
  logic [7:0] sio_m [5];
  logic [7:0] lat_m [8];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
    .cfg_rdata(cfg_rdata), .io_addr(io_addr), .io_wdata(io_wdata), .io_we(io_we),
    .io_rdata(io_rdata), .pin_in(pin_in), .alt_func_out(alt_func_out),
    .alt_func_oe(alt_func_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [63:0] exp_oe();
    logic [63:0] v;
    for (int n = 0; n < 64; n++) begin
      if (n / 8 < 5) v[n] = sio_m[n/8][n%8] ? oe_m[n/8][n%8] : alt_func_oe[n];
      else           v[n] = oe_m[n/8][n%8];
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_out();
    logic [63:0] v;
    for (int n = 0; n < 64; n++) begin
      if (n / 8 < 5) v[n] = sio_m[n/8][n%8] ? lat_m[n/8][n%8] : alt_func_out[n];
      else           v[n] = lat_m[n/8][n%8];
    end
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input int g);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = oe_m[g][b] ? lat_m[g][b] : pin_in[g*8+b];
    return v;
  endfunction

  function automatic logic [7:0] exp_cfg(input logic [7:0] a);
    if (a >= 8'hC8 && a <= 8'hCF) return oe_m[a - 8'hC8];
    if (a >= 8'hC0 && a <= 8'hC4) return sio_m[a - 8'hC0];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_pads(input string req);
    chk({req, " pad_oe"}, pad_oe, exp_oe());
    chk({req, " pad_out"}, pad_out, exp_out());
  endtask

  // Write taken at the next posedge; returns at the negedge after it.
  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 8'hC8 && a <= 8'hCF) oe_m[a - 8'hC8] = d;
    else if (a >= 8'hC0 && a <= 8'hC4) sio_m[a - 8'hC0] = d;
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] off;
    @(negedge clk);
    io_addr = a; io_wdata = d; io_we = 1'b1;
    @(negedge clk);
    io_we = 1'b0;
    off = a - IOB;
    if (off < 16'd8) lat_m[off[2:0]] = d;
  endtask

  task automatic cfg_rd(input logic [7:0] a, input string req);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    chk(req, 64'(cfg_rdata), 64'(exp_cfg(a)));
  endtask

  task automatic io_rd(input logic [15:0] a, input string req);
    logic [15:0] off;
    @(negedge clk);
    io_addr = a;
    @(negedge clk);
    off = a - IOB;
    chk(req, 64'(io_rdata), (off < 16'd8) ? 64'(exp_rd(int'(off))) : 64'h0);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] a8;
    logic [15:0] a16;
    void'($urandom(32'd2024));
    for (int g = 0; g < 8; g++) begin oe_m[g] = '0; lat_m[g] = '0; end
    for (int g = 0; g < 5; g++) sio_m[g] = '0;

    repeat (4) @(negedge clk);
    // R1: reset values are visible while reset is held.
    chk("R1 pad_oe in reset", pad_oe, 64'h0);
    chk("R1 pad_out in reset", pad_out, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check_pads("R1");
    cfg_rd(8'hC8, "R1 oe read");
    cfg_rd(8'hC0, "R1 sio read");
    io_rd(IOB, "R1 data read");

    // R2/R3/R7: one line of switched group 3.
    cfg_wr(8'hC3, 8'hFF);
    cfg_wr(8'hCB, 8'h20);
    settle();
    chk("R2 single line 29", pad_oe, 64'h1 << 29);
    cfg_rd(8'hCB, "R3 oe readback");
    io_wr(IOB + 16'd3, 8'h20);
    settle();
    check_pads("R7 group3");
    chk("R7 line 29 driven high", 64'(pad_out[29]), 64'h1);

    // R9: fixed group 6 needs no switch.
    cfg_wr(8'hCE, 8'h81);
    settle();
    chk("R9 group6 oe", 64'(pad_oe[55:48]), 64'h81);
    // R10: pad updates one clock after the write edge.
    @(negedge clk);
    io_addr = IOB + 16'd6; io_wdata = 8'hFF; io_we = 1'b1;
    @(negedge clk);
    io_we = 1'b0;
    chk("R10 pad not yet updated", 64'(pad_out[55:48]), 64'h00);
    lat_m[6] = 8'hFF;
    @(negedge clk);
    chk("R10 pad updated", 64'(pad_out[55:48]), 64'hFF);

    // R8: group 1 handed to alternate function.
    cfg_wr(8'hC9, 8'hFF);
    io_wr(IOB + 16'd1, 8'h0F);
    @(negedge clk);
    alt_func_oe[15:8] = 8'h3C; alt_func_out[15:8] = 8'hA5;
    settle();
    settle();
    check_pads("R8 alt group1");
    chk("R8 alt oe bits", 64'(pad_oe[15:8]), 64'h3C);

    // R4: dead simple-I/O addresses.
    cfg_wr(8'hC5, 8'hFF);
    cfg_wr(8'hC7, 8'hFF);
    cfg_rd(8'hC5, "R4 dead read");
    cfg_rd(8'hC6, "R4 dead read 2");
    settle();
    check_pads("R4 no effect");

    // R11: writes outside the data window.
    io_wr(IOB + 16'd8, 8'h55);
    io_wr(IOB - 16'd1, 8'h55);
    settle();
    check_pads("R11 no effect");
    io_rd(IOB + 16'd9, "R11 outside read");

    // R6: two-flop latency on group 2 (all inputs).
    @(negedge clk);
    io_addr = IOB + 16'd2;
    @(negedge clk);
    pin_in[23:16] = 8'h6B;
    @(negedge clk);
    chk("R6 edge1 old", 64'(io_rdata), 64'h00);
    @(negedge clk);
    chk("R6 edge2 old", 64'(io_rdata), 64'h00);
    @(negedge clk);
    chk("R6 edge3 new", 64'(io_rdata), 64'h6B);
    // R5/R6: output lines read latch, inputs read pins.
    cfg_wr(8'hCA, 8'hF0);
    io_wr(IOB + 16'd2, 8'h90);
    io_rd(IOB + 16'd2, "R5 R6 mixed read");

    // Random phase; R12 covers the registered read data.
    for (int i = 0; i < 500; i++) begin
      case ($urandom % 6)
        0: begin cfg_wr(8'hC8 + 8'($urandom % 8), 8'($urandom)); settle(); check_pads("R3 R9 random"); end
        1: begin cfg_wr(8'hC0 + 8'($urandom % 8), 8'($urandom)); settle(); check_pads("R4 R7 random"); end
        2: begin
          a16 = IOB + 16'($urandom % 10) - 16'd1;
          io_wr(a16, 8'($urandom)); settle(); check_pads("R5 R11 random");
        end
        3: begin a16 = IOB + 16'($urandom % 10); io_rd(a16, "R12 io read"); end
        4: begin a8 = 8'hC0 + 8'($urandom % 16); cfg_rd(a8, "R12 cfg read"); end
        default: begin
          @(negedge clk);
          pin_in = {$urandom, $urandom};
          alt_func_out = {8'($urandom), $urandom};
          alt_func_oe  = {8'($urandom), $urandom};
          repeat (3) @(negedge clk);
          check_pads("R8 random alt");
        end
      endcase
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule